// File: doc/BRIEF.md
# Rotating Column-Write Command Generator

This block turns a stream of captured video lines into write commands for a frame-buffer memory controller so that the stored picture is turned a quarter turn clockwise. An input frame of 480 lines, each 640 pixels long, is written into a 1280x720 output buffer. Each input line is stored as a vertical strip one pixel wide and 640 pixels tall, starting at output row 40. The first line of a frame goes to column 1159, and each later line goes one column further left, so the last line lands in column 680.

The capture path gives a one-cycle frame-start pulse and a one-cycle pulse at the end of each line. The block counts lines from the frame-start pulse. It samples the output line stride (in pixels) at frame start. For each line it presents a command on a valid/ready interface. The command carries a byte address of ((40 × stride) + column) × 2, a width of 1 and a height of 640. Line pulses that arrive while a command is still waiting are counted in a small saturating pending counter. Two sticky flags report a lost line and a line past the end of the frame.

Top module: `rot_cmd_gen`

## Requirements
- R1: After reset, cmd_valid, err_extra and err_ovf are all 0, and the stride in use is 1280.
- R2: Each accepted line pulse gives exactly one handshaked command. Every command has cmd_width = 1 and cmd_height = 640.
- R3: The address of the first command of a frame is ((40 × S) + 1159) × 2, where S is the value of stride_in in the cycle where frame_start is high.
- R4: Each later command in the same frame has an address 2 bytes lower than the one before it (one column left). The 480th line of a frame is written at column 680.
- R5: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_addr does not change on the next cycle, unless frame_start is high.
- R6: Line pulses that arrive while a command is waiting are not lost. Up to 7 of them wait in the pending counter, and their commands come out in arrival order once cmd_ready goes high.
- R7: When the pending counter holds 7 and another line is accepted with no command launching in that cycle, that line is dropped and err_ovf goes high. err_ovf stays high until the next frame_start. Later lines continue from the next column.
- R8: A line pulse after the 480th in a frame produces no command and sets err_extra. err_extra stays high until the next frame_start.
- R9: frame_start clears the line count, the pending counter and both error flags, and drops cmd_valid on the next cycle. A line pulse in the same cycle as frame_start is ignored.
- R10: Changes to stride_in between frame_start pulses have no effect on the addresses of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse at the start of an input frame |
| line_done | input | 1 | One-cycle pulse at the end of each input line |
| stride_in | input | 16 | Output line stride in pixels, sampled at frame start |
| cmd_valid | output | 1 | A write command is being offered |
| cmd_ready | input | 1 | The memory controller takes the command |
| cmd_addr | output | 32 | Byte address of the top pixel of the column |
| cmd_width | output | 16 | Transfer width in pixels (always 1) |
| cmd_height | output | 16 | Transfer height in pixels (input line length) |
| err_extra | output | 1 | Sticky: a line arrived past the end of the frame |
| err_ovf | output | 1 | Sticky: the pending counter was full and a line was dropped |

## Verification
The address path is tested with four different stride values, including zero and the largest 16-bit value. This separates a correct stride multiply from one that is truncated or ignored. A full 480-line frame checks the descending column walk and its end at column 680, and shows whether the line limit is off by one. Runs with cmd_ready held low check that the waiting command stays stable, that queued lines come out in order, and that the counter saturates at exactly the eighth waiting line. A mid-frame stride change and a frame_start that arrives while a command is waiting separate sampling at frame start from reading the stride live.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int ADDR_W   = 32;
    localparam int DIM_W    = 16;
    localparam int STRIDE_W = 16;

    typedef logic [ADDR_W-1:0]   addr_t;
    typedef logic [DIM_W-1:0]    dim_t;
    typedef logic [STRIDE_W-1:0] stride_t;
endpackage

// File: rtl/rot_line_tracker.sv
// Counts the lines of the current frame and accepts at most N_LINES of them.
module rot_line_tracker #(
    parameter int N_LINES = 480,
    localparam int LW     = $clog2(N_LINES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic line_done,
    output logic accept,
    output logic err_extra
);
    typedef struct packed {
        logic [LW-1:0] cnt;
        logic          err;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        if (frame_start) begin
            st_d.cnt = '0;
            st_d.err = 1'b0;
        end else if (line_done) begin
            if (st_q.cnt < LW'(N_LINES)) begin
                accept   = 1'b1;
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_extra = st_q.err;
endmodule

// File: rtl/rot_pend_queue.sv
// Saturating counter of lines still waiting for their command.
module rot_pend_queue #(
    parameter int QW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic pop,
    output logic nonempty,
    output logic err_ovf
);
    typedef struct packed {
        logic [QW-1:0] cnt;
        logic          ovf;
    } pq_t;

    pq_t st_d, st_q;
    logic full;

    assign full = (st_q.cnt == {QW{1'b1}});

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (push && !pop) begin
            if (full) st_d.ovf = 1'b1;
            else      st_d.cnt = st_q.cnt + 1'b1;
        end else if (!push && pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign nonempty = (st_q.cnt != '0);
    assign err_ovf  = st_q.ovf;
endmodule

// File: rtl/rot_addr_calc.sv
// Byte address of the top pixel of the column for a zero-based line index.
module rot_addr_calc
    import rot_pkg::*;
#(
    parameter int FIRST_COL = 1159,
    parameter int ROW_OFS   = 40,
    parameter int BPP       = 2,
    parameter int LW        = 9
) (
    input  logic [LW-1:0] idx,
    input  stride_t       stride,
    output addr_t         addr
);
    addr_t col;
    addr_t row_base;

    always_comb begin
        col      = ADDR_W'(FIRST_COL) - ADDR_W'(idx);
        row_base = ADDR_W'(ROW_OFS) * ADDR_W'(stride);
        addr     = (row_base + col) * ADDR_W'(BPP);
    end
endmodule

// File: rtl/rot_cmd_gen.sv
module rot_cmd_gen
    import rot_pkg::*;
#(
    parameter int LINE_PIX   = 640,
    parameter int N_LINES    = 480,
    parameter int FIRST_COL  = 1159,
    parameter int ROW_OFS    = 40,
    parameter int BPP        = 2,
    parameter int QW         = 3,
    parameter int DEF_STRIDE = 1280,
    localparam int LW        = $clog2(N_LINES + 1)
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    frame_start,
    input  logic    line_done,
    input  stride_t stride_in,
    output logic    cmd_valid,
    input  logic    cmd_ready,
    output addr_t   cmd_addr,
    output dim_t    cmd_width,
    output dim_t    cmd_height,
    output logic    err_extra,
    output logic    err_ovf
);
    typedef struct packed {
        logic          valid;
        addr_t         addr;
        logic [LW-1:0] idx;
        stride_t       stride;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    accept;
    logic    pend;
    logic    launch;
    addr_t   next_addr;

    rot_line_tracker #(.N_LINES(N_LINES)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .line_done   (line_done),
        .accept      (accept),
        .err_extra   (err_extra)
    );

    rot_pend_queue #(.QW(QW)) u_pq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (frame_start),
        .push     (accept),
        .pop      (launch),
        .nonempty (pend),
        .err_ovf  (err_ovf)
    );

    rot_addr_calc #(
        .FIRST_COL (FIRST_COL),
        .ROW_OFS   (ROW_OFS),
        .BPP       (BPP),
        .LW        (LW)
    ) u_ac (
        .idx    (st_q.idx),
        .stride (st_q.stride),
        .addr   (next_addr)
    );

    // A new command may load when the register is empty or being taken now.
    assign launch = pend && (!st_q.valid || cmd_ready) && !frame_start;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.valid  = 1'b0;
            st_d.idx    = '0;
            st_d.stride = stride_in;
        end else begin
            if (st_q.valid && cmd_ready) st_d.valid = 1'b0;
            if (launch) begin
                st_d.valid = 1'b1;
                st_d.addr  = next_addr;
                st_d.idx   = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.stride <= STRIDE_W'(DEF_STRIDE);
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_valid  = st_q.valid;
    assign cmd_addr   = st_q.addr;
    assign cmd_width  = DIM_W'(1);
    assign cmd_height = DIM_W'(LINE_PIX);
endmodule

// File: rtl/rot_cmd_gen_chk.sv
module rot_cmd_gen_chk
    import rot_pkg::*;
#(
    parameter int BPP = 2
) (
    input logic  clk,
    input logic  rst_n,
    input logic  frame_start,
    input logic  cmd_valid,
    input logic  cmd_ready,
    input addr_t cmd_addr,
    input logic  err_extra,
    input logic  err_ovf
);
    addr_t prev_q;
    logic  have_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            have_prev_q <= 1'b0;
            prev_q      <= '0;
        end else if (cmd_valid && cmd_ready) begin
            have_prev_q <= 1'b1;
            prev_q      <= cmd_addr;
        end
    end

    // R5: a waiting command is held unchanged
    a_r5_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready && !frame_start) |=> (cmd_valid && $stable(cmd_addr)));

    // R4: consecutive commands of a frame step one column left
    a_r4_descend: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && have_prev_q && !frame_start)
            |-> (cmd_addr == prev_q - ADDR_W'(BPP)));

    // R9: frame start drops any offered command
    a_r9_fs_drops: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !cmd_valid);

    // R8: extra-line flag is sticky within a frame
    a_r8_extra_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_extra && !frame_start) |=> err_extra);

    // R7: overflow flag is sticky within a frame
    a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ovf && !frame_start) |=> err_ovf);

    // R9: flags are cleared by frame start
    a_r9_fs_clears: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!err_extra && !err_ovf));
endmodule

bind rot_cmd_gen rot_cmd_gen_chk #(.BPP(BPP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_addr    (cmd_addr),
    .err_extra   (err_extra),
    .err_ovf     (err_ovf)
);

// File: tb/sim_rot_cmd_gen.sv
`timescale 1ns/1ps
module sim_rot_cmd_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        line_done = 1'b0;
    logic [15:0] stride_in = 16'd1280;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_addr;
    logic [15:0] cmd_width;
    logic [15:0] cmd_height;
    logic        err_extra;
    logic        err_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rot_cmd_gen u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_done(line_done),
        .stride_in(stride_in), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_width(cmd_width), .cmd_height(cmd_height),
        .err_extra(err_extra), .err_ovf(err_ovf)
    );

    // Handshake log
    logic [31:0] log_addr [0:1023];
    int ncmd      = 0;
    int shape_bad = 0;
    always @(posedge clk) begin
        if (rst_n && cmd_valid && cmd_ready) begin
            if (ncmd < 1024) log_addr[ncmd] <= cmd_addr;
            if (cmd_width != 16'd1 || cmd_height != 16'd640) shape_bad <= shape_bad + 1;
            ncmd <= ncmd + 1;
        end
    end

    // Stimulus table: stride, lines to send, expected first address
    localparam int NT = 4;
    localparam int unsigned T_STRIDE [NT] = '{1280, 2048, 0, 65535};
    localparam int unsigned T_LINES  [NT] = '{5, 4, 3, 2};
    localparam longint unsigned T_FIRST [NT] = '{104718, 166158, 2318, 5245118};

    function automatic longint unsigned exp_addr(input longint unsigned s, input longint unsigned col);
        return ((40 * s) + col) * 2;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input longint unsigned act, input longint unsigned expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic start_frame(input int unsigned s);
        stride_in   = 16'(s);
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
        tick();
    endtask

    task automatic send_line();
        line_done = 1'b1;
        tick();
        line_done = 1'b0;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) tick();
        // R1: reset state
        chk(cmd_valid == 1'b0, "R1 valid in reset", cmd_valid, 0);
        rst_n = 1'b1;
        tick();
        chk(cmd_valid == 1'b0 && err_extra == 1'b0 && err_ovf == 1'b0, "R1 outputs after reset",
            {cmd_valid, err_extra, err_ovf}, 0);
        // R1: default stride used before any frame start
        base = ncmd;
        send_line();
        repeat (4) tick();
        chk(ncmd - base == 1, "R1 one command", ncmd - base, 1);
        chk(log_addr[base] == 32'(exp_addr(1280, 1159)), "R1 default stride address",
            log_addr[base], exp_addr(1280, 1159));

        // Table walk: R2 R3 R4 under several strides
        for (int t = 0; t < NT; t++) begin
            start_frame(T_STRIDE[t]);
            base = ncmd;
            for (int l = 0; l < int'(T_LINES[t]); l++) send_line();
            repeat (4) tick();
            chk(ncmd - base == int'(T_LINES[t]), "R2 command count", ncmd - base, T_LINES[t]);
            chk(log_addr[base] == 32'(T_FIRST[t]), "R3 first address", log_addr[base], T_FIRST[t]);
            chk(log_addr[base] == 32'(exp_addr(T_STRIDE[t], 1159)), "R3 formula",
                log_addr[base], exp_addr(T_STRIDE[t], 1159));
            for (int l = 1; l < int'(T_LINES[t]); l++)
                chk(log_addr[base + l] == 32'(T_FIRST[t] - 2 * l), "R4 step",
                    log_addr[base + l], T_FIRST[t] - 2 * l);
        end
        chk(shape_bad == 0, "R2 width/height", shape_bad, 0);

        // R4 R8: full frame, then one extra line
        start_frame(1280);
        base = ncmd;
        for (int l = 0; l < 480; l++) send_line();
        repeat (4) tick();
        chk(ncmd - base == 480, "R4 full frame count", ncmd - base, 480);
        chk(log_addr[base + 479] == 32'(exp_addr(1280, 680)), "R4 last column 680",
            log_addr[base + 479], exp_addr(1280, 680));
        chk(err_extra == 1'b0, "R8 no flag at 480", err_extra, 0);
        send_line();
        repeat (4) tick();
        chk(ncmd - base == 480, "R8 extra line ignored", ncmd - base, 480);
        chk(err_extra == 1'b1, "R8 flag set", err_extra, 1);
        repeat (3) tick();
        chk(err_extra == 1'b1, "R8 flag sticky", err_extra, 1);
        start_frame(1280);
        chk(err_extra == 1'b0, "R9 frame start clears extra", err_extra, 0);

        // R5 R6: hold under back-pressure, queue further lines
        cmd_ready = 1'b0;
        base = ncmd;
        send_line();
        repeat (2) tick();
        chk(cmd_valid == 1'b1, "R5 valid offered", cmd_valid, 1);
        chk(cmd_addr == 32'(exp_addr(1280, 1159)), "R5 address offered", cmd_addr, exp_addr(1280, 1159));
        for (int l = 0; l < 3; l++) send_line();
        repeat (5) tick();
        chk(cmd_valid == 1'b1 && cmd_addr == 32'(exp_addr(1280, 1159)), "R5 held stable",
            cmd_addr, exp_addr(1280, 1159));
        cmd_ready = 1'b1;
        repeat (8) tick();
        chk(ncmd - base == 4, "R6 queued lines issued", ncmd - base, 4);
        for (int l = 0; l < 4; l++)
            chk(log_addr[base + l] == 32'(exp_addr(1280, 1159 - l)), "R6 order",
                log_addr[base + l], exp_addr(1280, 1159 - l));
        chk(err_ovf == 1'b0, "R6 no overflow", err_ovf, 0);

        // R7: saturate the pending counter
        start_frame(1280);
        cmd_ready = 1'b0;
        base = ncmd;
        for (int l = 0; l < 8; l++) send_line();
        repeat (2) tick();
        chk(err_ovf == 1'b0, "R7 eight lines fit", err_ovf, 0);
        send_line();
        repeat (2) tick();
        chk(err_ovf == 1'b1, "R7 ninth overflows", err_ovf, 1);
        cmd_ready = 1'b1;
        repeat (12) tick();
        chk(ncmd - base == 8, "R7 commands after drop", ncmd - base, 8);
        chk(log_addr[base + 7] == 32'(exp_addr(1280, 1152)), "R7 last column",
            log_addr[base + 7], exp_addr(1280, 1152));
        send_line();
        repeat (4) tick();
        chk(log_addr[base + 8] == 32'(exp_addr(1280, 1151)), "R7 continues next column",
            log_addr[base + 8], exp_addr(1280, 1151));
        chk(err_ovf == 1'b1, "R7 flag sticky", err_ovf, 1);
        start_frame(1280);
        chk(err_ovf == 1'b0, "R9 frame start clears ovf", err_ovf, 0);

        // R9: frame start drops a waiting command; coincident line ignored
        cmd_ready = 1'b0;
        send_line();
        repeat (2) tick();
        chk(cmd_valid == 1'b1, "R9 command waiting", cmd_valid, 1);
        base = ncmd;
        stride_in   = 16'd1280;
        frame_start = 1'b1;
        line_done   = 1'b1;
        tick();
        frame_start = 1'b0;
        line_done   = 1'b0;
        tick();
        chk(cmd_valid == 1'b0, "R9 valid dropped", cmd_valid, 0);
        cmd_ready = 1'b1;
        repeat (4) tick();
        chk(ncmd == base, "R9 coincident line ignored", ncmd - base, 0);
        send_line();
        repeat (4) tick();
        chk(log_addr[base] == 32'(exp_addr(1280, 1159)), "R9 count restarted",
            log_addr[base], exp_addr(1280, 1159));

        // R10: stride change mid-frame
        start_frame(1280);
        stride_in = 16'd2048;
        base = ncmd;
        send_line();
        send_line();
        repeat (4) tick();
        chk(log_addr[base] == 32'(exp_addr(1280, 1159)), "R10 stride kept",
            log_addr[base], exp_addr(1280, 1159));
        chk(log_addr[base + 1] == 32'(exp_addr(1280, 1158)), "R10 stride kept second",
            log_addr[base + 1], exp_addr(1280, 1158));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule